// File: doc/BRIEF.md
# Double-Buffered Eight-Channel Converter Code Bank

This block models, in synchronous logic, the digital front end of an eight-channel 14-bit converter. A host drives a parallel data bus, a 3-bit channel address and four active-low controls: chip select, write, load and clear. Every channel holds two codes. The first is an input register that the host fills one channel at a time. The second is a DAC register that sets what the channel presents. One load control moves every input register into its DAC register together, so all channels can change on the same cycle.

All controls are level-sensitive. A register whose enable condition holds is rewritten on every clock for as long as that condition lasts. When write and load are open at the same time, bus data flows straight through to the addressed channel's output. Clear does not alter any register. It masks every output to the ground-reference state and raises a per-channel force flag. Releasing clear brings back the codes held in the DAC registers.

The pins are sampled into a bus-state register. Its four named states are ST_HOLD (no window open), ST_WRITE (chip select and write low), ST_LOAD (load low) and ST_THRU (all three low). On every clock the next state is chosen purely from the pins: any state moves to ST_HOLD, ST_WRITE, ST_LOAD or ST_THRU according to which windows are open. An output process decodes the state into the write and load enables, and these act on the registers at the following edge.

Top module: `dacbank_top`

## Requirements
- R1: After reset, every channel code reads mid-scale 0x2000 and every force flag is 0. Both input and DAC registers start at 0x2000.
- R2: When chip select and write are both low, only the input register of the channel named by the address is written. Address 3'b000 selects channel 0 and 3'b111 selects channel 7, with bit 2 as the MSB. The channel output does not change until a load.
- R3: If chip select is high or write is high, no input register changes.
- R4: While load is low, every DAC register takes its channel's input register on the same cycle. While load is high, every DAC register holds.
- R5: When chip select, write and load are all low, the bus data appears directly as the addressed channel's code.
- R6: While clear is low, all eight force flags are 1 together and every channel code reads 0x2000. Writes and loads still update the registers during this time.
- R7: When clear is high, every code equals its DAC register value and all flags are 0. Releasing clear brings back the previously held codes.
- R8: Pins sampled at one rising edge show their effect on the outputs after the next rising edge, a latency of two edges.
- R9: A write whose address changes while the window stays open updates the channel addressed in each cycle. A stable address updates exactly one channel.
- R10: Codes are offset binary. 0x0000 is the most negative value, 0x2000 is mid-scale and 0x3FFF is the most positive, and all three pass through unaltered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_data | input | 14 | Parallel code bus |
| chan_addr | input | 3 | Channel address, bit 2 MSB |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write |
| ld_n | input | 1 | Active-low global load |
| clr_n | input | 1 | Active-low output clear |
| chan_code | output | 112 | Channel k code at bits [14k+13:14k] |
| gnd_force | output | 8 | Per-channel force-to-ground flag |

## Verification
The bench checks that a write alone never reaches an output. A design that bypassed the input register would show the new code early. It checks that a write with only one of chip select or write low is ignored, which catches a decoder that ORs the two controls. Clear is exercised while a write and a load are in flight and then released: a design that zeroed the registers would come back at 0x2000 instead of the loaded values. The two-edge latency, pass-through with all three controls low, and an address that moves inside one write window are each probed. A wrong pipeline depth, a lost pass-through path, or a latch that captures only the first address would each show up as a wrong code on a named channel.

// File: rtl/dacbank_pkg.sv
package dacbank_pkg;

    localparam int CODE_W = 14;
    localparam int NUM_CH = 8;

    // bus-state register encoding, one state per combination of open windows
    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_WRITE = 2'd1,
        ST_LOAD  = 2'd2,
        ST_THRU  = 2'd3
    } bus_state_e;

endpackage

// File: rtl/dacbank_ctrl.sv
module dacbank_ctrl
    import dacbank_pkg::*;
#(
    parameter int CODE_W = 14,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              ld_n,
    input  logic              clr_n,
    input  logic [ADDR_W-1:0] chan_addr,
    input  logic [CODE_W-1:0] bus_data,
    output logic              wr_en,
    output logic              ld_en,
    output logic              clear_on,
    output logic [ADDR_W-1:0] addr_q,
    output logic [CODE_W-1:0] data_q
);

    bus_state_e state_q;
    bus_state_e state_nx;
    logic       wr_win;
    logic       ld_win;

    assign wr_win = !cs_n && !wr_n;
    assign ld_win = !ld_n;

    // next state depends only on which windows the pins hold open
    always_comb begin
        unique case ({wr_win, ld_win})
            2'b00:   state_nx = ST_HOLD;
            2'b10:   state_nx = ST_WRITE;
            2'b01:   state_nx = ST_LOAD;
            default: state_nx = ST_THRU;
        endcase
    end

    // state register with the bus capture that travels with it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_HOLD;
            addr_q   <= '0;
            data_q   <= '0;
            clear_on <= 1'b0;
        end else begin
            state_q  <= state_nx;
            addr_q   <= chan_addr;
            data_q   <= bus_data;
            clear_on <= !clr_n;
        end
    end

    // output decode of the state
    always_comb begin
        unique case (state_q)
            ST_HOLD: begin
                wr_en = 1'b0;
                ld_en = 1'b0;
            end
            ST_WRITE: begin
                wr_en = 1'b1;
                ld_en = 1'b0;
            end
            ST_LOAD: begin
                wr_en = 1'b0;
                ld_en = 1'b1;
            end
            ST_THRU: begin
                wr_en = 1'b1;
                ld_en = 1'b1;
            end
            default: begin
                wr_en = 1'b0;
                ld_en = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/dacbank_chan.sv
module dacbank_chan #(
    parameter int CODE_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic              ld_en,
    input  logic [CODE_W-1:0] data_q,
    output logic [CODE_W-1:0] in_code,
    output logic [CODE_W-1:0] dac_code
);

    localparam logic [CODE_W-1:0] MID_CODE = {1'b1, {(CODE_W-1){1'b0}}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_code  <= MID_CODE;
            dac_code <= MID_CODE;
        end else begin
            if (hit) begin
                in_code <= data_q;
            end
            // with both windows open the bus value flows straight through
            if (ld_en) begin
                dac_code <= hit ? data_q : in_code;
            end
        end
    end

endmodule

// File: rtl/dacbank_mask.sv
module dacbank_mask #(
    parameter int CODE_W = 14,
    parameter int NUM_CH = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear_on,
    input  logic [NUM_CH*CODE_W-1:0] dac_vec,
    output logic [NUM_CH*CODE_W-1:0] chan_code,
    output logic [NUM_CH-1:0]        gnd_force
);

    localparam logic [CODE_W-1:0] MID_CODE = {1'b1, {(CODE_W-1){1'b0}}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnd_force <= '0;
        end else begin
            gnd_force <= {NUM_CH{clear_on}};
        end
    end

    for (genvar k = 0; k < NUM_CH; k++) begin : g_out
        assign chan_code[k*CODE_W +: CODE_W] =
            gnd_force[k] ? MID_CODE : dac_vec[k*CODE_W +: CODE_W];
    end

endmodule

// File: rtl/dacbank_top.sv
module dacbank_top #(
    parameter int CODE_W = dacbank_pkg::CODE_W,
    parameter int NUM_CH = dacbank_pkg::NUM_CH,
    localparam int ADDR_W = $clog2(NUM_CH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [CODE_W-1:0]        bus_data,
    input  logic [ADDR_W-1:0]        chan_addr,
    input  logic                     cs_n,
    input  logic                     wr_n,
    input  logic                     ld_n,
    input  logic                     clr_n,
    output logic [NUM_CH*CODE_W-1:0] chan_code,
    output logic [NUM_CH-1:0]        gnd_force
);

    logic                     wr_en;
    logic                     ld_en;
    logic                     clear_on;
    logic [ADDR_W-1:0]        addr_q;
    logic [CODE_W-1:0]        data_q;
    logic [NUM_CH*CODE_W-1:0] in_vec;
    logic [NUM_CH*CODE_W-1:0] dac_vec;

    dacbank_ctrl #(
        .CODE_W (CODE_W),
        .ADDR_W (ADDR_W)
    ) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .wr_n      (wr_n),
        .ld_n      (ld_n),
        .clr_n     (clr_n),
        .chan_addr (chan_addr),
        .bus_data  (bus_data),
        .wr_en     (wr_en),
        .ld_en     (ld_en),
        .clear_on  (clear_on),
        .addr_q    (addr_q),
        .data_q    (data_q)
    );

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        logic hit;
        assign hit = wr_en && (addr_q == ADDR_W'(k));

        dacbank_chan #(
            .CODE_W (CODE_W)
        ) chan_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .hit      (hit),
            .ld_en    (ld_en),
            .data_q   (data_q),
            .in_code  (in_vec[k*CODE_W +: CODE_W]),
            .dac_code (dac_vec[k*CODE_W +: CODE_W])
        );
    end

    dacbank_mask #(
        .CODE_W (CODE_W),
        .NUM_CH (NUM_CH)
    ) mask_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_on  (clear_on),
        .dac_vec   (dac_vec),
        .chan_code (chan_code),
        .gnd_force (gnd_force)
    );

endmodule

// File: rtl/dacbank_chk.sv
module dacbank_chk #(
    parameter int CODE_W = 14,
    parameter int NUM_CH = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cs_n,
    input logic                     wr_n,
    input logic                     ld_n,
    input logic                     clr_n,
    input logic [NUM_CH*CODE_W-1:0] in_vec,
    input logic [NUM_CH*CODE_W-1:0] dac_vec,
    input logic [NUM_CH*CODE_W-1:0] chan_code,
    input logic [NUM_CH-1:0]        gnd_force
);

    localparam logic [CODE_W-1:0] MID_CODE = {1'b1, {(CODE_W-1){1'b0}}};

    logic [1:0]               cyc;
    logic                     warm;
    logic [NUM_CH*CODE_W-1:0] in_prev;
    logic [NUM_CH-1:0]        in_chg;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc <= 2'd0;
        end else if (cyc != 2'd3) begin
            cyc <= cyc + 2'd1;
        end
        in_prev <= in_vec;
    end

    assign warm = (cyc >= 2'd2);

    for (genvar k = 0; k < NUM_CH; k++) begin : g_chg
        assign in_chg[k] = in_vec[k*CODE_W +: CODE_W] != in_prev[k*CODE_W +: CODE_W];
    end

    p_reset_mid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dac_vec == {NUM_CH{MID_CODE}}) && (gnd_force == '0));

    p_one_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(in_chg) <= 1);

    p_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && ($past(cs_n, 2) || $past(wr_n, 2))) |-> $stable(in_vec));

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(ld_n, 2)) |-> $stable(dac_vec));

    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && !$past(clr_n, 2)) |-> (gnd_force == '1));

    p_uniform_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (gnd_force == '0) || (gnd_force == '1));

    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(clr_n, 2)) |-> ((gnd_force == '0) && (chan_code == dac_vec)));

endmodule

bind dacbank_top dacbank_chk #(
    .CODE_W (CODE_W),
    .NUM_CH (NUM_CH)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .wr_n      (wr_n),
    .ld_n      (ld_n),
    .clr_n     (clr_n),
    .in_vec    (in_vec),
    .dac_vec   (dac_vec),
    .chan_code (chan_code),
    .gnd_force (gnd_force)
);

// File: tb/dacbank_top_tb_top.sv
module dacbank_top_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [13:0]  bus_data = '0;
    logic [2:0]   chan_addr = '0;
    logic         cs_n = 1'b1;
    logic         wr_n = 1'b1;
    logic         ld_n = 1'b1;
    logic         clr_n = 1'b1;
    logic [111:0] chan_code;
    logic [7:0]   gnd_force;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    dacbank_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_data  (bus_data),
        .chan_addr (chan_addr),
        .cs_n      (cs_n),
        .wr_n      (wr_n),
        .ld_n      (ld_n),
        .clr_n     (clr_n),
        .chan_code (chan_code),
        .gnd_force (gnd_force)
    );

    typedef struct packed {
        logic        cs;
        logic        wr;
        logic        ld;
        logic        clr;
        logic [2:0]  a;
        logic [13:0] d;
        logic [2:0]  ch;
        logic [13:0] e;
        logic        f;
    } vec_t;

    // cs wr ld clr addr data | check channel, expected code, expected flag
    localparam vec_t TBL [14] = '{
        '{1'b0, 1'b0, 1'b1, 1'b1, 3'd3, 14'h1234, 3'd3, 14'h2000, 1'b0}, // R2 no output before load
        '{1'b0, 1'b0, 1'b1, 1'b1, 3'd0, 14'h0000, 3'd0, 14'h2000, 1'b0}, // R2
        '{1'b1, 1'b0, 1'b1, 1'b1, 3'd5, 14'h3FFF, 3'd5, 14'h2000, 1'b0}, // R3 cs high
        '{1'b1, 1'b1, 1'b0, 1'b1, 3'd0, 14'h0000, 3'd3, 14'h1234, 1'b0}, // R4 load
        '{1'b1, 1'b1, 1'b1, 1'b1, 3'd0, 14'h0000, 3'd0, 14'h0000, 1'b0}, // R10 zero code
        '{1'b0, 1'b1, 1'b1, 1'b1, 3'd5, 14'h1111, 3'd5, 14'h2000, 1'b0}, // R3 wr high
        '{1'b1, 1'b1, 1'b0, 1'b1, 3'd0, 14'h0000, 3'd5, 14'h2000, 1'b0}, // R3 blocked writes
        '{1'b0, 1'b0, 1'b0, 1'b1, 3'd7, 14'h3FFF, 3'd7, 14'h3FFF, 1'b0}, // R5 R10 full scale
        '{1'b0, 1'b0, 1'b0, 1'b1, 3'd6, 14'h0ABC, 3'd6, 14'h0ABC, 1'b0}, // R5
        '{1'b1, 1'b1, 1'b1, 1'b0, 3'd0, 14'h0000, 3'd3, 14'h2000, 1'b1}, // R6 clear
        '{1'b0, 1'b0, 1'b1, 1'b0, 3'd1, 14'h0777, 3'd1, 14'h2000, 1'b1}, // R6 write in clear
        '{1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 14'h0000, 3'd3, 14'h2000, 1'b1}, // R6 load in clear
        '{1'b1, 1'b1, 1'b1, 1'b1, 3'd0, 14'h0000, 3'd3, 14'h1234, 1'b0}, // R7 release
        '{1'b1, 1'b1, 1'b1, 1'b1, 3'd0, 14'h0000, 3'd1, 14'h0777, 1'b0}  // R7 value loaded in clear
    };

    task automatic drive(input logic cs, input logic wr, input logic ld, input logic clr,
                         input logic [2:0] a, input logic [13:0] d);
        cs_n      = cs;
        wr_n      = wr;
        ld_n      = ld;
        clr_n     = clr;
        chan_addr = a;
        bus_data  = d;
    endtask

    task automatic idle();
        drive(1'b1, 1'b1, 1'b1, 1'b1, 3'd0, 14'h0000);
    endtask

    task automatic expect_ch(input string req, input int ch, input logic [13:0] exp_code,
                             input logic exp_flag);
        logic [13:0] got;
        got = chan_code[ch*14 +: 14];
        checks++;
        if (got !== exp_code || gnd_force[ch] !== exp_flag) begin
            fails++;
            $display("FAIL %s ch%0d code=%h flag=%b expected code=%h flag=%b",
                     req, ch, got, gnd_force[ch], exp_code, exp_flag);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R8 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int c = 0; c < 8; c++) expect_ch("R1", c, 14'h2000, 1'b0);

        // vector table
        for (int i = 0; i < 14; i++) begin
            drive(TBL[i].cs, TBL[i].wr, TBL[i].ld, TBL[i].clr, TBL[i].a, TBL[i].d);
            @(negedge clk);
            idle();
            @(negedge clk);
            expect_ch("R2-R7 table", int'(TBL[i].ch), TBL[i].e, TBL[i].f);
        end

        // R8: pass-through visible only after the second edge
        drive(1'b0, 1'b0, 1'b0, 1'b1, 3'd2, 14'h0155);
        @(negedge clk);
        idle();
        expect_ch("R8 one edge", 2, 14'h2000, 1'b0);
        @(negedge clk);
        expect_ch("R8 two edges", 2, 14'h0155, 1'b0);

        // R9: address moves inside one open write window
        drive(1'b0, 1'b0, 1'b1, 1'b1, 3'd4, 14'h0444);
        @(negedge clk);
        drive(1'b0, 1'b0, 1'b1, 1'b1, 3'd5, 14'h0555);
        @(negedge clk);
        idle();
        @(negedge clk);
        drive(1'b1, 1'b1, 1'b0, 1'b1, 3'd0, 14'h0000);
        @(negedge clk);
        idle();
        @(negedge clk);
        expect_ch("R9 first addr", 4, 14'h0444, 1'b0);
        expect_ch("R9 second addr", 5, 14'h0555, 1'b0);
        expect_ch("R9 untouched", 2, 14'h0155, 1'b0);

        // R9: stable address held for three cycles reaches one channel only
        drive(1'b0, 1'b0, 1'b1, 1'b1, 3'd0, 14'h0F0F);
        repeat (3) @(negedge clk);
        idle();
        @(negedge clk);
        drive(1'b1, 1'b1, 1'b0, 1'b1, 3'd0, 14'h0000);
        @(negedge clk);
        idle();
        @(negedge clk);
        expect_ch("R9 target", 0, 14'h0F0F, 1'b0);
        expect_ch("R9 neighbour", 1, 14'h0777, 1'b0);
        expect_ch("R9 neighbour", 6, 14'h0ABC, 1'b0);
        expect_ch("R9 neighbour", 7, 14'h3FFF, 1'b0);

        // R1: reset mid-run returns everything to mid-scale
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int c = 0; c < 8; c++) expect_ch("R1 rerun", c, 14'h2000, 1'b0);

        summary();
        $finish;
    end

endmodule